// File: doc/BRIEF.md
# Capture Line Write Address Generator

This block produces the memory start address of every captured video line, together with the number of bytes that line carries. Configuration (frame buffer base, window width, pixel packing, progressive or interlaced format, field interleave and vertical inversion) is taken from static inputs. A frame-start strobe latches that configuration and reloads the line pointer. Each line-start strobe then emits one address and steps the pointer for the next line.

The line pitch is the byte count of one line rounded up to a whole number of 32-byte units. When the two fields of an interlaced frame share one buffer, lines of a field are two pitches apart and the second field begins one pitch into the buffer. In inverse mode the image is written bottom-up: the first line lands at the last line slot and the pointer moves downward. Writing to memory has its own enable, separate from the strobes. Clearing it suppresses the write request but does not stop line tracking.

Top module: `line_addr_gen`

## Requirements
- R1: After reset, `line_valid` is 0, and `line_addr` and `line_bytes` are both 0.
- R2: The bytes per line equal the window width times 1 when `pack8`=1 and `ycc_mode`=0. In every other case they equal the window width times 2. The value is reported on `line_bytes` with every emitted line.
- R3: The pitch in 32-byte units is (bytes per line + 31) >> 5. The line step is one pitch, or two pitches when `interlaced`=1 and `fld_interleave`=1 (double mode).
- R4: The base, in 32-byte units, is {`base_hi`,`base_lo`}: `base_lo` holds byte-address bits 20:5 and `base_hi` holds bits 27:21. `line_addr` is a byte address whose bits 4:0 are 0.
- R5: In normal mode the first line after a frame start is at base + field offset, and each later line adds one step.
- R6: `field_id` is sampled at frame start. In double mode, field 1 gives a field offset of one pitch. In every other case the field offset is 0.
- R7: In inverse mode (`invert`=1) the first line is at base + field offset + (`field_lines` − 1) × step, and each later line subtracts one step.
- R8: `line_valid` pulses for one cycle, one cycle after a line strobe, only if `wr_en` was 1 with that strobe. `line_addr` updates and the pointer advances whether or not `wr_en` is set.
- R9: The configuration is latched at frame start. Changes made during a frame do not alter that frame's step or byte count.
- R10: A line strobe in the same cycle as a frame start emits the first line of the new frame.
- R11: Address arithmetic wraps modulo 2^28 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_lo | input | 16 | Buffer base, byte-address bits 20:5 |
| base_hi | input | ADDR_W-21 | Buffer base, byte-address bits 27:21 |
| win_width | input | WIDTH_W | Window width in pixels |
| field_lines | input | LINE_W | Lines per field (at least 1), used for inverse start |
| pack8 | input | 1 | One byte per pixel (8-bit or companded raw) |
| ycc_mode | input | 1 | YCbCr input, always two bytes per pixel |
| interlaced | input | 1 | Interlaced frame format |
| fld_interleave | input | 1 | Both fields share one interleaved buffer |
| invert | input | 1 | Store image bottom-up |
| field_id | input | 1 | Current field, sampled at frame start |
| wr_en | input | 1 | Memory write enable |
| frame_start | input | 1 | Frame start strobe |
| line_start | input | 1 | Line start strobe |
| line_addr | output | ADDR_W | Start byte address of emitted line |
| line_bytes | output | WIDTH_W+1 | Bytes in emitted line |
| line_valid | output | 1 | Write request for emitted line |

## Verification
A wrong pointer or a wrong latched step shows up at `line_addr` one cycle after the next line strobe. From then on every following address of the frame stays off by a constant amount or drifts further. A stale latched field or inversion flag shows up in the first address after a frame start. The bench compares every emitted address and byte count against a model over random frames. It adds directed cases at pitch rounding boundaries, at the address wrap, with the enable held low, and with configuration changes in the middle of a frame.

// File: rtl/line_addr_gen.sv
module line_addr_gen #(
  parameter int ADDR_W  = 28,
  parameter int WIDTH_W = 13,
  parameter int LINE_W  = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [15:0]          base_lo,
  input  logic [ADDR_W-22:0]   base_hi,
  input  logic [WIDTH_W-1:0]   win_width,
  input  logic [LINE_W-1:0]    field_lines,
  input  logic                 pack8,
  input  logic                 ycc_mode,
  input  logic                 interlaced,
  input  logic                 fld_interleave,
  input  logic                 invert,
  input  logic                 field_id,
  input  logic                 wr_en,
  input  logic                 frame_start,
  input  logic                 line_start,
  output logic [ADDR_W-1:0]    line_addr,
  output logic [WIDTH_W:0]     line_bytes,
  output logic                 line_valid
);

  localparam int UNIT_W  = ADDR_W - 5;
  localparam int PITCH_W = WIDTH_W - 3;

  logic [WIDTH_W:0]   bytes_c;
  logic [WIDTH_W+1:0] round_c;
  logic [UNIT_W-1:0]  base_c, pitch_c, step_c, foff_c, span_c, start_c;
  logic [LINE_W-1:0]  nm1_c;
  logic               dbl_c;

  assign bytes_c = (pack8 && !ycc_mode) ? {1'b0, win_width} : {win_width, 1'b0};
  assign round_c = {1'b0, bytes_c} + (WIDTH_W+2)'(31);
  assign pitch_c = {{(UNIT_W-PITCH_W){1'b0}}, round_c[WIDTH_W+1:5]};
  assign dbl_c   = interlaced && fld_interleave;
  assign step_c  = dbl_c ? {pitch_c[UNIT_W-2:0], 1'b0} : pitch_c;
  assign foff_c  = (dbl_c && field_id) ? pitch_c : '0;
  assign base_c  = {base_hi, base_lo};
  assign nm1_c   = field_lines - LINE_W'(1);
  assign span_c  = step_c * {{(UNIT_W-LINE_W){1'b0}}, nm1_c};
  assign start_c = base_c + foff_c + (invert ? span_c : '0);

  logic [UNIT_W-1:0]  cur_q, step_q, out_q;
  logic [WIDTH_W:0]   bytes_q;
  logic               inv_q, emitted_q;

  function automatic logic [UNIT_W-1:0] advance(input logic [UNIT_W-1:0] v,
                                                input logic [UNIT_W-1:0] s,
                                                input logic dn);
    return dn ? v - s : v + s;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q      <= '0;
      step_q     <= '0;
      out_q      <= '0;
      bytes_q    <= '0;
      inv_q      <= 1'b0;
      emitted_q  <= 1'b0;
      line_bytes <= '0;
      line_valid <= 1'b0;
    end else begin
      line_valid <= line_start && wr_en;
      if (frame_start) begin
        step_q    <= step_c;
        inv_q     <= invert;
        bytes_q   <= bytes_c;
        emitted_q <= line_start;
        if (line_start) begin
          out_q      <= start_c;
          line_bytes <= bytes_c;
          cur_q      <= advance(start_c, step_c, invert);
        end else begin
          cur_q <= start_c;
        end
      end else if (line_start) begin
        out_q      <= cur_q;
        line_bytes <= bytes_q;
        cur_q      <= advance(cur_q, step_q, inv_q);
        emitted_q  <= 1'b1;
      end
    end
  end

  assign line_addr = {out_q, 5'b0};

  assert_valid_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid |-> $past(line_start && wr_en));

  assert_step_track_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && !frame_start && emitted_q && !inv_q) |=>
      (line_addr[ADDR_W-1:5] == $past(line_addr[ADDR_W-1:5]) + $past(step_q)));

  assert_step_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && !frame_start && emitted_q && inv_q) |=>
      (line_addr[ADDR_W-1:5] == $past(line_addr[ADDR_W-1:5]) - $past(step_q)));

  assert_first_base_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && line_start && !invert && !(interlaced && fld_interleave && field_id)) |=>
      (line_addr[ADDR_W-1:5] == {$past(base_hi), $past(base_lo)}));

  assert_bytes_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && !frame_start && emitted_q) |=> $stable(line_bytes));

endmodule

// File: tb/test_line_addr_gen.sv
module test_line_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] base_lo = '0;
  logic [6:0]  base_hi = '0;
  logic [12:0] win_width = 13'd1;
  logic [11:0] field_lines = 12'd1;
  logic        pack8 = 0, ycc_mode = 0, interlaced = 0, fld_interleave = 0;
  logic        invert = 0, field_id = 0, wr_en = 0, frame_start = 0, line_start = 0;
  logic [27:0] line_addr;
  logic [13:0] line_bytes;
  logic        line_valid;

  int checks = 0, fails = 0;
  bit done = 0;

  // snapshot taken at frame start
  int s_base, s_w, s_n; bit s_pk, s_ycc, s_il, s_fi, s_inv, s_fid;

  always #2 clk = ~clk;

  line_addr_gen i_line_addr_gen (.*);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_bytes();
    return (s_pk && !s_ycc) ? s_w : 2 * s_w;
  endfunction

  function automatic logic [27:0] exp_addr(input int k);
    longint pitch, step, foff, idx, u;
    bit dbl;
    pitch = (exp_bytes() + 31) >> 5;
    dbl   = s_il && s_fi;
    step  = dbl ? 2 * pitch : pitch;
    foff  = (dbl && s_fid) ? pitch : 0;
    idx   = s_inv ? (s_n - 1 - k) : k;
    u     = (s_base + foff + idx * step) & 64'h7FFFFF;
    return {u[22:0], 5'b0};
  endfunction

  task automatic snap();
    s_base = int'({base_hi, base_lo}); s_w = int'(win_width); s_n = int'(field_lines);
    s_pk = pack8; s_ycc = ycc_mode; s_il = interlaced; s_fi = fld_interleave;
    s_inv = invert; s_fid = field_id;
  endtask

  task automatic do_frame(input bit with_line, input bit we);
    @(negedge clk);
    snap();
    frame_start = 1; line_start = with_line; wr_en = we;
    @(negedge clk);
    frame_start = 0; line_start = 0;
  endtask

  task automatic do_line(input int k, input bit we, input string tag);
    @(negedge clk);
    line_start = 1; wr_en = we;
    @(negedge clk);
    line_start = 0;
    chk(line_addr == exp_addr(k), tag, line_addr, exp_addr(k));
    chk(line_bytes == 14'(exp_bytes()), "R2 bytes", line_bytes, exp_bytes());
    chk(line_valid == we, "R8 valid", line_valid, we);
  endtask

  task automatic set_cfg(input int base, input int w, input int n, input bit pk, input bit ycc,
                         input bit il, input bit fi, input bit inv, input bit fid);
    {base_hi, base_lo} = 23'(base); win_width = 13'(w); field_lines = 12'(n);
    pack8 = pk; ycc_mode = ycc; interlaced = il; fld_interleave = fi; invert = inv; field_id = fid;
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd4711);
    repeat (3) @(negedge clk);
    chk(line_valid == 0 && line_addr == 0 && line_bytes == 0, "R1 reset", line_addr, 0);
    rst_n = 1;

    // R3 rounding boundary: 16 px at 2 bytes -> pitch 1, 17 px -> pitch 2
    set_cfg(100, 16, 4, 0, 0, 0, 0, 0, 0);
    do_frame(0, 1);
    for (int k = 0; k < 3; k++) do_line(k, 1, "R3 pitch one");
    set_cfg(100, 17, 4, 0, 0, 0, 0, 0, 0);
    do_frame(0, 1);
    for (int k = 0; k < 3; k++) do_line(k, 1, "R3 pitch two");
    // R2 ycc forces two bytes even with pack8
    set_cfg(7, 40, 3, 1, 1, 0, 0, 0, 0);
    do_frame(0, 1);
    for (int k = 0; k < 2; k++) do_line(k, 1, "R2 ycc two bytes");
    set_cfg(7, 40, 3, 1, 0, 0, 0, 0, 0);
    do_frame(0, 1);
    for (int k = 0; k < 2; k++) do_line(k, 1, "R2 packed one byte");
    // R6 field 1 offset in double mode, and none without interleave
    set_cfg(500, 64, 5, 0, 0, 1, 1, 0, 1);
    do_frame(0, 1);
    for (int k = 0; k < 3; k++) do_line(k, 1, "R6 field one interleave");
    set_cfg(500, 64, 5, 0, 0, 1, 0, 0, 1);
    do_frame(0, 1);
    for (int k = 0; k < 2; k++) do_line(k, 1, "R6 no interleave");
    // R7 inverse interlaced
    set_cfg(1000, 100, 6, 0, 0, 1, 1, 1, 0);
    do_frame(0, 1);
    for (int k = 0; k < 6; k++) do_line(k, 1, "R7 inverse");
    // R10 same-cycle strobes
    set_cfg(321, 50, 4, 0, 0, 0, 0, 0, 0);
    do_frame(1, 1);
    chk(line_addr == exp_addr(0), "R10 same cycle", line_addr, exp_addr(0));
    chk(line_valid == 1, "R10 valid", line_valid, 1);
    for (int k = 1; k < 3; k++) do_line(k, 1, "R10 follow");
    // R8 write enable low: no pulse, pointer still moves
    set_cfg(42, 30, 4, 0, 0, 0, 0, 0, 0);
    do_frame(0, 0);
    do_line(0, 0, "R8 disabled line");
    do_line(1, 0, "R8 disabled line");
    do_line(2, 1, "R8 resume");
    // R9 mid-frame change ignored
    set_cfg(800, 70, 8, 0, 0, 0, 0, 0, 0);
    do_frame(0, 1);
    do_line(0, 1, "R9 before change");
    set_cfg(9, 900, 8, 1, 0, 1, 1, 1, 1);
    do_line(1, 1, "R9 after change");
    do_line(2, 1, "R9 after change");
    // R11 wrap and R4 high base bits
    set_cfg(23'h7FFFFE, 160, 8, 0, 0, 0, 0, 0, 0);
    do_frame(0, 1);
    for (int k = 0; k < 4; k++) do_line(k, 1, "R11 wrap");
    set_cfg(23'h5A0001, 10, 2, 0, 0, 0, 0, 0, 0);
    do_frame(0, 1);
    do_line(0, 1, "R4 base split");

    // random frames
    for (int f = 0; f < 40; f++) begin
      int n, nl;
      n = 1 + ($urandom % 40);
      set_cfg(int'($urandom % 32'h800000), 1 + ($urandom % 4000), n,
              $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2);
      nl = (n < 6) ? n : 6;
      do_frame(0, 1);
      for (int k = 0; k < nl; k++) do_line(k, ($urandom % 4) != 0, "R5 random frame");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule